// File: doc/BRIEF.md
# Platform System Control Ports

This block is the byte-wide register file that sits behind a small part of a system board's I/O space. It answers three address regions. One is a lone special port at 0x0092. One is a control window of 0x52 ports starting at 0x0800. The last is a pair of scratch bytes at 0x0398 and 0x0399. Firmware uses it in four ways:

- It reads fixed identification constants.
- It keeps a system control byte.
- It flips two password-protect lock bits by writing to their ports.
- It requests a soft reset, a byte-order change or an I/O-map change by writing trigger bits.

The bus side is a plain synchronous strobe interface. Address, write data and the write or read strobe are sampled on a rising clock edge. Read data is registered, so it is valid from the edge that samples the read strobe until the next read. The soft-reset request leaves the block as a one-cycle pulse. The little-endian request and the unsupported-map error are sticky flags that only reset clears. Acting on these outputs, storing NVRAM contents and handling caches are all left to other blocks.

Top module: `sysctl_ports`

## Requirements
- R1: After reset all outputs are low or zero: bus_rdata = 0x00, sys_ctrl = 0x00, nv_lock = 2'b00, soft_rst_req, le_mode_req and iomap_err all low. Reads of 0x081C, 0x0398 and 0x0399 then return 0x00.
- R2: A write to 0x0092 with data bit 7 set drives soft_rst_req high for exactly the one cycle after the write edge. A write with bit 7 clear gives no pulse.
- R3: A write to 0x0092 with data bit 6 set sets le_mode_req from the write edge on. The flag stays set until reset.
- R4: Reads return these fixed values: 0x0092 gives 0x40, 0x080C gives 0xFC, 0x0818 gives 0x00, 0x0823 gives 0x03 and 0x0850 gives 0x00.
- R5: Port 0x081C holds a read/write byte. A read returns the last value written, and the sys_ctrl output shows that byte from the write edge on.
- R6: Each write to 0x0810 inverts nv_lock[0], and each write to 0x0812 inverts nv_lock[1], whatever the written data.
- R7: A write to 0x0850 with data bit 7 set sets iomap_err, which stays set until reset. A write there with bit 7 clear leaves iomap_err unchanged.
- R8: A read of any address that maps to no register returns 0xFF. This covers undefined ports inside 0x0800..0x0851 (including 0x0808, 0x0810, 0x0812 and 0x0814) and all addresses outside the three regions.
- R9: Writes to 0x0808, 0x0814, undefined ports and unmapped addresses change no output and no stored byte.
- R10: Ports 0x0398 and 0x0399 are independent storage bytes. A read of either returns the last value written to that byte.
- R11: bus_rdata changes only on the edge that samples bus_rd. It holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | I/O port address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| soft_rst_req | output | 1 | One-cycle soft-reset request |
| le_mode_req | output | 1 | Sticky little-endian mode request |
| iomap_err | output | 1 | Sticky unsupported I/O-map request |
| nv_lock | output | 2 | NVRAM password-protect lock bits |
| sys_ctrl | output | 8 | Stored system control byte |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle. They also assume that the address and write data are stable around each sampling edge. The bench drives all inputs on the falling edge and issues each access through a task that raises exactly one strobe for one cycle. Back-to-back strobes are the only overlap, and the bench never exercises a read and a write to the same port in the same cycle, so a read that races a write is left outside the checked behaviour. Sweeps cover every address in and around each region, all 256 values of the control byte, and repeated lock writes with varied data.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned AW     = 16;
  localparam int unsigned DW     = 8;
  localparam int unsigned SCR_N  = 2;
  localparam int unsigned SCR_IW = (SCR_N > 1) ? $clog2(SCR_N) : 1;
  localparam int unsigned WIN_LEN = 'h52;

  localparam logic [AW-1:0] PORT_SPECIAL = 16'h0092;
  localparam logic [AW-1:0] WIN_BASE     = 16'h0800;
  localparam logic [AW-1:0] SCR_BASE     = 16'h0398;

  // offsets inside the control window
  localparam logic [7:0] OFF_EQUIP = 8'h0C;
  localparam logic [7:0] OFF_LOCKA = 8'h10;
  localparam logic [7:0] OFF_LOCKB = 8'h12;
  localparam logic [7:0] OFF_KEY   = 8'h18;
  localparam logic [7:0] OFF_CTRL  = 8'h1C;
  localparam logic [7:0] OFF_L2    = 8'h23;
  localparam logic [7:0] OFF_MAP   = 8'h50;

  localparam logic [DW-1:0] VAL_SPECIAL = 8'h40;
  localparam logic [DW-1:0] VAL_EQUIP   = 8'hFC;
  localparam logic [DW-1:0] VAL_KEY     = 8'h00;
  localparam logic [DW-1:0] VAL_L2      = 8'h03;
  localparam logic [DW-1:0] VAL_MAP     = 8'h00;
  localparam logic [DW-1:0] VAL_OPEN    = 8'hFF;

  localparam int unsigned BIT_SOFTRST = 7;
  localparam int unsigned BIT_ENDIAN  = 6;
  localparam int unsigned BIT_MAPBAD  = 7;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_SPECIAL,
    SEL_EQUIP,
    SEL_KEY,
    SEL_CTRL,
    SEL_L2,
    SEL_MAP,
    SEL_LOCKA,
    SEL_LOCKB,
    SEL_SCR,
    SEL_QUIET
  } sel_e;

  typedef struct packed {
    sel_e              sel;
    logic [SCR_IW-1:0] scr_idx;
  } hit_t;

  function automatic hit_t classify(input logic [AW-1:0] a);
    hit_t h;
    logic [AW-1:0] off;
    h.sel     = SEL_NONE;
    h.scr_idx = '0;
    off       = a - WIN_BASE;
    if (a == PORT_SPECIAL) begin
      h.sel = SEL_SPECIAL;
    end else if (a >= SCR_BASE && a < SCR_BASE + AW'(SCR_N)) begin
      h.sel     = SEL_SCR;
      h.scr_idx = SCR_IW'(a - SCR_BASE);
    end else if (a >= WIN_BASE && a < WIN_BASE + AW'(WIN_LEN)) begin
      case (off[7:0])
        OFF_EQUIP: h.sel = SEL_EQUIP;
        OFF_LOCKA: h.sel = SEL_LOCKA;
        OFF_LOCKB: h.sel = SEL_LOCKB;
        OFF_KEY:   h.sel = SEL_KEY;
        OFF_CTRL:  h.sel = SEL_CTRL;
        OFF_L2:    h.sel = SEL_L2;
        OFF_MAP:   h.sel = SEL_MAP;
        default:   h.sel = SEL_QUIET;
      endcase
    end
    return h;
  endfunction

  function automatic logic [DW-1:0] fixed_value(input sel_e s);
    case (s)
      SEL_SPECIAL: return VAL_SPECIAL;
      SEL_EQUIP:   return VAL_EQUIP;
      SEL_KEY:     return VAL_KEY;
      SEL_L2:      return VAL_L2;
      SEL_MAP:     return VAL_MAP;
      default:     return VAL_OPEN;
    endcase
  endfunction

  function automatic logic [1:0] next_lock(input logic [1:0] cur,
                                           input logic flip_a,
                                           input logic flip_b);
    return cur ^ {flip_b, flip_a};
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  output sel_e              sel,
  output logic [SCR_IW-1:0] scr_idx,
  output logic              ev_reset,
  output logic              ev_endian,
  output logic              ev_mapbad,
  output logic              ev_ctrl_wr,
  output logic              ev_lock_a,
  output logic              ev_lock_b,
  output logic              ev_scr_wr
);

  hit_t hit;

  always_comb begin
    hit        = classify(addr);
    sel        = hit.sel;
    scr_idx    = hit.scr_idx;
    ev_reset   = wr && (hit.sel == SEL_SPECIAL) && wdata[BIT_SOFTRST];
    ev_endian  = wr && (hit.sel == SEL_SPECIAL) && wdata[BIT_ENDIAN];
    ev_mapbad  = wr && (hit.sel == SEL_MAP) && wdata[BIT_MAPBAD];
    ev_ctrl_wr = wr && (hit.sel == SEL_CTRL);
    ev_lock_a  = wr && (hit.sel == SEL_LOCKA);
    ev_lock_b  = wr && (hit.sel == SEL_LOCKB);
    ev_scr_wr  = wr && (hit.sel == SEL_SCR);
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DW-1:0]              wdata,
  input  logic [SCR_IW-1:0]          scr_idx,
  input  logic                       ev_reset,
  input  logic                       ev_endian,
  input  logic                       ev_mapbad,
  input  logic                       ev_ctrl_wr,
  input  logic                       ev_lock_a,
  input  logic                       ev_lock_b,
  input  logic                       ev_scr_wr,
  output logic [DW-1:0]              sys_ctrl,
  output logic [1:0]                 nv_lock,
  output logic [SCR_N-1:0][DW-1:0]   scratch,
  output logic                       soft_rst_req,
  output logic                       le_mode_req,
  output logic                       iomap_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_ctrl     <= '0;
      nv_lock      <= 2'b00;
      soft_rst_req <= 1'b0;
      le_mode_req  <= 1'b0;
      iomap_err    <= 1'b0;
    end else begin
      soft_rst_req <= ev_reset;
      if (ev_endian) le_mode_req <= 1'b1;
      if (ev_mapbad) iomap_err <= 1'b1;
      if (ev_ctrl_wr) sys_ctrl <= wdata;
      nv_lock <= next_lock(nv_lock, ev_lock_a, ev_lock_b);
    end
  end

  for (genvar g = 0; g < SCR_N; g++) begin : g_scr
    logic hit_me;
    assign hit_me = ev_scr_wr && (scr_idx == SCR_IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scratch[g] <= '0;
      else if (hit_me) scratch[g] <= wdata;
    end
  end

  assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reset |=> soft_rst_req);
  assert_pulse_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_reset |=> !soft_rst_req);
  assert_endian_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    le_mode_req |=> le_mode_req);
  assert_endian_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_endian |=> le_mode_req);
  assert_map_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iomap_err |=> iomap_err);
  assert_map_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_mapbad && !iomap_err) |=> !iomap_err);
  assert_lock_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock_a |=> (nv_lock[0] != $past(nv_lock[0])));
  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_lock_b |=> $stable(nv_lock[1]));
  assert_ctrl_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ctrl_wr |=> (sys_ctrl == $past(wdata)));
  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ctrl_wr |=> $stable(sys_ctrl));

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd,
  input  sel_e                     sel,
  input  logic [SCR_IW-1:0]        scr_idx,
  input  logic [DW-1:0]            sys_ctrl,
  input  logic [SCR_N-1:0][DW-1:0] scratch,
  output logic [DW-1:0]            rdata
);

  logic [DW-1:0] rd_value;

  always_comb begin
    case (sel)
      SEL_CTRL: rd_value = sys_ctrl;
      SEL_SCR:  rd_value = scratch[scr_idx];
      default:  rd_value = fixed_value(sel);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd) rdata <= rd_value;
  end

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
  assert_special_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_SPECIAL) |=> (rdata == 8'h40));
  assert_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (sel == SEL_NONE || sel == SEL_QUIET)) |=> (rdata == 8'hFF));

endmodule

// File: rtl/sysctl_ports.sv
module sysctl_ports
  import sysctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          soft_rst_req,
  output logic          le_mode_req,
  output logic          iomap_err,
  output logic [1:0]    nv_lock,
  output logic [7:0]    sys_ctrl
);

  sel_e                     sel;
  logic [SCR_IW-1:0]        scr_idx;
  logic                     ev_reset, ev_endian, ev_mapbad, ev_ctrl_wr;
  logic                     ev_lock_a, ev_lock_b, ev_scr_wr;
  logic [SCR_N-1:0][DW-1:0] scratch;

  sysctl_decode u_dec (
    .addr       (bus_addr),
    .wr         (bus_wr),
    .wdata      (bus_wdata),
    .sel        (sel),
    .scr_idx    (scr_idx),
    .ev_reset   (ev_reset),
    .ev_endian  (ev_endian),
    .ev_mapbad  (ev_mapbad),
    .ev_ctrl_wr (ev_ctrl_wr),
    .ev_lock_a  (ev_lock_a),
    .ev_lock_b  (ev_lock_b),
    .ev_scr_wr  (ev_scr_wr)
  );

  sysctl_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdata        (bus_wdata),
    .scr_idx      (scr_idx),
    .ev_reset     (ev_reset),
    .ev_endian    (ev_endian),
    .ev_mapbad    (ev_mapbad),
    .ev_ctrl_wr   (ev_ctrl_wr),
    .ev_lock_a    (ev_lock_a),
    .ev_lock_b    (ev_lock_b),
    .ev_scr_wr    (ev_scr_wr),
    .sys_ctrl     (sys_ctrl),
    .nv_lock      (nv_lock),
    .scratch      (scratch),
    .soft_rst_req (soft_rst_req),
    .le_mode_req  (le_mode_req),
    .iomap_err    (iomap_err)
  );

  sysctl_rdmux u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (bus_rd),
    .sel      (sel),
    .scr_idx  (scr_idx),
    .sys_ctrl (sys_ctrl),
    .scratch  (scratch),
    .rdata    (bus_rdata)
  );

  assert_excl_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

endmodule

// File: tb/sim_sysctl_ports.sv
`timescale 1ns/1ps
module sim_sysctl_ports;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        soft_rst_req, le_mode_req, iomap_err;
  logic [1:0]  nv_lock;
  logic [7:0]  sys_ctrl;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0] m_ctl;
  logic [1:0] m_lock;
  logic [7:0] m_scr [2];
  logic       m_le, m_map;

  always #2 clk = ~clk;

  sysctl_ports u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    if (a == 'h92) return 8'h40;
    if (a == 'h398) return m_scr[0];
    if (a == 'h399) return m_scr[1];
    if (a >= 'h800 && a < 'h852) begin
      case (a - 'h800)
        'h0C: return 8'hFC;
        'h18: return 8'h00;
        'h1C: return m_ctl;
        'h23: return 8'h03;
        'h50: return 8'h00;
        default: return 8'hFF;
      endcase
    end
    return 8'hFF;
  endfunction

  function automatic string tag_of(input int a);
    if (a == 'h398 || a == 'h399) return "R10";
    if (a == 'h81C) return "R5";
    if (a == 'h92 || a == 'h80C || a == 'h818 || a == 'h823 || a == 'h850) return "R4";
    return "R8";
  endfunction

  task automatic chk_state(input string tag);
    chk({tag, " sys_ctrl"}, sys_ctrl, m_ctl);
    chk({tag, " nv_lock"}, nv_lock, m_lock);
    chk({tag, " le_mode_req"}, le_mode_req, m_le);
    chk({tag, " iomap_err"}, iomap_err, m_map);
    chk({tag, " soft_rst_req"}, soft_rst_req, 0);
  endtask

  task automatic model_reset();
    m_ctl = 0; m_lock = 0; m_scr[0] = 0; m_scr[1] = 0; m_le = 0; m_map = 0;
  endtask

  task automatic read_sweep(input int lo, input int hi);
    logic [7:0] d;
    for (int a = lo; a <= hi; a++) begin
      rd(16'(a), d);
      chk($sformatf("%s read 0x%0h", tag_of(a), a), d, exp_rd(a));
    end
  endtask

  initial begin
    logic [7:0] d;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", bus_rdata, 0);
    chk_state("R1");
    rd(16'h081C, d); chk("R1 ctrl read", d, 0);
    rd(16'h0398, d); chk("R1 scr0 read", d, 0);
    rd(16'h0399, d); chk("R1 scr1 read", d, 0);

    // R4 R8 R10 read sweeps
    read_sweep('h0090, 'h0094);
    read_sweep('h0396, 'h039B);
    read_sweep('h07F0, 'h0860);

    // R5 every control value
    for (int v = 0; v < 256; v++) begin
      wr(16'h081C, 8'(v));
      m_ctl = 8'(v);
      chk("R5 sys_ctrl out", sys_ctrl, v);
      rd(16'h081C, d);
      chk("R5 ctrl read", d, v);
    end

    // R6 lock toggles with varied data
    for (int k = 0; k < 10; k++) begin
      wr(16'h0810, 8'(k * 37));
      m_lock[0] = ~m_lock[0];
      chk("R6 lock a", nv_lock, m_lock);
      if (k % 3 == 0) begin
        wr(16'h0812, 8'(255 - k));
        m_lock[1] = ~m_lock[1];
        chk("R6 lock b", nv_lock, m_lock);
      end
    end

    // R10 scratch independence
    for (int v = 0; v < 16; v++) begin
      wr(16'h0398, 8'(v * 17)); m_scr[0] = 8'(v * 17);
      wr(16'h0399, 8'(~(v * 5))); m_scr[1] = 8'(~(v * 5));
      rd(16'h0398, d); chk("R10 scr0", d, m_scr[0]);
      rd(16'h0399, d); chk("R10 scr1", d, m_scr[1]);
    end

    // R9 writes with no effect
    for (int a = 'h07F8; a < 'h0858; a++) begin
      if (a == 'h81C || a == 'h810 || a == 'h812 || a == 'h850) continue;
      wr(16'(a), 8'hFF);
      chk_state($sformatf("R9 wr 0x%0h", a));
    end
    wr(16'h0397, 8'hFF); wr(16'h039A, 8'hFF); wr(16'h0093, 8'hFF);
    chk_state("R9 outside");
    read_sweep('h0398, 'h0399);

    // R11 hold
    rd(16'h080C, d);
    repeat (3) begin @(negedge clk); chk("R11 idle hold", bus_rdata, 8'hFC); end
    wr(16'h081C, 8'h5A); m_ctl = 8'h5A;
    chk("R11 write hold", bus_rdata, 8'hFC);

    // R2 soft reset pulse
    wr(16'h0092, 8'h00);
    chk("R2 no pulse", soft_rst_req, 0);
    chk("R3 no endian", le_mode_req, 0);
    wr(16'h0092, 8'h80);
    chk("R2 pulse high", soft_rst_req, 1);
    @(negedge clk);
    chk("R2 pulse low", soft_rst_req, 0);
    chk("R3 bit7 only", le_mode_req, 0);

    // R3 endian sticky
    wr(16'h0092, 8'h40);
    chk("R3 endian set", le_mode_req, 1);
    chk("R2 bit6 no pulse", soft_rst_req, 0);
    wr(16'h0092, 8'h00);
    repeat (4) @(negedge clk);
    chk("R3 endian sticky", le_mode_req, 1);

    // R7 map error
    wr(16'h0850, 8'h7F);
    chk("R7 bit7 clear", iomap_err, 0);
    wr(16'h0850, 8'h80);
    chk("R7 set", iomap_err, 1);
    wr(16'h0850, 8'h00);
    repeat (3) @(negedge clk);
    chk("R7 sticky", iomap_err, 1);

    // R1 mid-run reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    model_reset();
    chk("R1 rerst rdata", bus_rdata, 0);
    chk_state("R1 rerst");
    rst_n = 1'b1;
    read_sweep('h0398, 'h0399);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule